// File: doc/BRIEF.md
# Four-Line Fixed-Priority Interrupt Controller

This block collects interrupt requests from four sources whose line numbers are fixed in hardware: the timer on line 0, the second serial port on line 3, the first serial port on line 4 and the network-interface controller on line 5. It drives one interrupt output toward the CPU. When the CPU runs an acknowledge cycle, the controller returns an 8-bit vector. It also tracks which lines are in service, so that priorities nest.

Each request is latched on a rising edge of its source. A mask register can block individual lines, but the latched requests stay in place while masked. Priority is static and fully nested: a request can reach the CPU only if its line ranks above every line currently in service. The only way to retire a serviced line is a specific end-of-interrupt command that names it.

Software reaches the controller through a small register bus with four addresses:

| Address | Write | Read |
|---|---|---|
| 0 | Vector base | Vector base |
| 1 | Mask | Mask |
| 2 | End-of-interrupt command | In-service bits |
| 3 | (none) | Request bits |

Top module: `fixed_irq_ctrl`

## Requirements
- R1: The four sources sit in fixed slots bound to lines 0, 3, 4 and 5. In the mask, in-service and request registers, line n occupies bit n. Bits 1, 2, 6 and 7 read as 0, and writes to those bits are ignored.
- R2: A rising edge on a source sets that line's request bit on the next clock edge, as read at address 3. A source held high sets it only once. A source that is already high during reset is not seen as an edge.
- R3: A set mask bit (address 1) keeps that line from raising `cpu_irq_o` and from being acknowledged. Its latched request is kept. After reset all four lines are masked.
- R4: Priority is line 0, then 3, then 4, then 5. An acknowledge grants the highest eligible request. The vector is base (address 0, reset value 0x20) plus the line number, modulo 256. It appears on `vec_o` one cycle after the `inta_i` pulse.
- R5: A request is eligible only if it is unmasked and its line ranks strictly above every in-service line. `cpu_irq_o` is high exactly when an eligible request exists, and it follows a state change by one clock.
- R6: An acknowledge clears the granted request bit and sets its in-service bit (address 2). If a rising edge arrives on the same line in the acknowledge cycle, the request bit remains set.
- R7: Writing a line number in bits 2:0 to address 2 clears that line's in-service bit.
- R8: An end-of-interrupt that names a line not in service, or a line with no source, changes no state.
- R9: An acknowledge with no eligible request returns base + 7 and leaves the request and in-service bits unchanged.
- R10: After reset, the request and in-service bits are 0, `cpu_irq_o` is 0, `vec_o` is 0 and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 4 | Sources by slot: bit 0 is line 0, bit 1 is line 3, bit 2 is line 4, bit 3 is line 5 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| inta_i | input | 1 | One-cycle interrupt acknowledge |
| vec_o | output | 8 | Vector returned by the last acknowledge |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The acknowledge of a line and a new rising edge on that same line can land in the same clock. In that case the grant clears the request bit while the edge tries to set it again. The bench raises a line's source in exactly the cycle where `inta_i` is high for that line's pending request. It then reads the in-service and request registers and expects the line in both. After an end-of-interrupt, a second acknowledge must return the same vector, which shows the new edge was kept and not absorbed by the grant.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC = 4;
  localparam int LW   = 3;
  localparam int DW   = 8;
  typedef logic [LW-1:0] line_t;
  localparam line_t LINE_OF [NSRC] = '{3'd0, 3'd3, 3'd4, 3'd5};

  typedef enum logic [1:0] {
    RA_BASE = 2'd0,
    RA_MASK = 2'd1,
    RA_SVC  = 2'd2,
    RA_PEND = 2'd3
  } reg_addr_e;

  function automatic logic [DW-1:0] spread(input logic [NSRC-1:0] s);
    logic [DW-1:0] v;
    v = '0;
    for (int i = 0; i < NSRC; i++) v[LINE_OF[i]] = s[i];
    return v;
  endfunction

  function automatic logic [NSRC-1:0] gather(input logic [DW-1:0] v);
    logic [NSRC-1:0] s;
    for (int i = 0; i < NSRC; i++) s[i] = v[LINE_OF[i]];
    return s;
  endfunction
endpackage

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src,
  input  logic [N-1:0] clr,
  output logic [N-1:0] req
);
  logic [N-1:0] src_q;
  logic [N-1:0] rise;

  assign rise = src & ~src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= src;
      req   <= '0;
    end else begin
      src_q <= src;
      req   <= (req & ~clr) | rise;
    end
  end

  // R2: a seen rising edge is latched
  a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((req & $past(rise)) == $past(rise)));

  // R6: a grant clears its request unless a new edge arrived with it
  a_r6_grant_clears: assert property (@(posedge clk) disable iff (rst)
    (clr != '0) |=> ((req & $past(clr & ~rise)) == '0));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] isr,
  output logic [N-1:0] grant,
  output logic         any
);
  logic blocked;

  always_comb begin
    grant   = '0;
    any     = 1'b0;
    blocked = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (isr[i]) blocked = 1'b1;
      if (!blocked && !any && req[i] && !mask[i]) begin
        grant[i] = 1'b1;
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqc_isr.sv
module irqc_isr #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] eoi_clr,
  output logic [N-1:0] isr
);
  always_ff @(posedge clk) begin
    if (rst) isr <= '0;
    else     isr <= (isr & ~eoi_clr) | set;
  end

  // R7: a specific EOI on an in-service line retires it
  a_r7_eoi_clears: assert property (@(posedge clk) disable iff (rst)
    ((eoi_clr & isr) != '0) |=> ((isr & $past(eoi_clr)) == '0));

  // R8: an EOI that hits nothing leaves in-service state alone
  a_r8_eoi_ignored: assert property (@(posedge clk) disable iff (rst)
    (((eoi_clr & isr) == '0) && (set == '0)) |=> $stable(isr));
endmodule

// File: rtl/fixed_irq_ctrl.sv
module fixed_irq_ctrl
  import irqc_pkg::*;
#(
  parameter logic [DW-1:0] BASE_RST = 8'h20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            inta_i,
  output logic [DW-1:0]   vec_o,
  output logic            cpu_irq_o
);
  localparam logic [DW-1:0] SPUR_OFS = DW'(7);

  logic [DW-1:0]   base_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] req, isr, grant, set, eoi_clr;
  logic            any, take, eoi_fire;
  line_t           gline;

  assign take     = inta_i & any;
  assign set      = take ? grant : '0;
  assign eoi_fire = bus_wr && (bus_addr == RA_SVC);

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      eoi_clr[i] = eoi_fire && (bus_wdata[LW-1:0] == LINE_OF[i]);
  end

  always_comb begin
    gline = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) gline = LINE_OF[i];
  end

  irqc_req_latch #(.N(NSRC)) u_req (
    .clk(clk), .rst(rst), .src(src_i), .clr(set), .req(req)
  );

  irqc_prio #(.N(NSRC)) u_prio (
    .req(req), .mask(mask_q), .isr(isr), .grant(grant), .any(any)
  );

  irqc_isr #(.N(NSRC)) u_isr (
    .clk(clk), .rst(rst), .set(set), .eoi_clr(eoi_clr), .isr(isr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= BASE_RST;
      mask_q    <= '1;
      vec_o     <= '0;
      cpu_irq_o <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == RA_BASE) base_q <= bus_wdata;
      if (bus_wr && bus_addr == RA_MASK) mask_q <= gather(bus_wdata);
      if (inta_i) vec_o <= take ? base_q + DW'(gline) : base_q + SPUR_OFS;
      cpu_irq_o <= any;
      case (bus_addr)
        RA_BASE: bus_rdata <= base_q;
        RA_MASK: bus_rdata <= spread(mask_q);
        RA_SVC:  bus_rdata <= spread(isr);
        default: bus_rdata <= spread(req);
      endcase
    end
  end

  // R3/R5: the CPU line is raised only for an unmasked pending request
  a_r3_irq_needs_unmasked: assert property (@(posedge clk) disable iff (rst)
    cpu_irq_o |-> $past(|(req & ~mask_q)));

  // R5: a newly serviced line always ranks above all others in service
  a_r5_nested_grant: assert property (@(posedge clk) disable iff (rst)
    take |=> ((isr & (~isr + NSRC'(1))) == (isr & ~$past(isr))));

  // R9: an empty acknowledge yields base + 7 and changes no state
  a_r9_spurious_vec: assert property (@(posedge clk) disable iff (rst)
    (inta_i && !any && !bus_wr) |=> ((vec_o == $past(base_q) + SPUR_OFS)
                                      && $stable(isr) && $stable(req)));
endmodule

// File: tb/fixed_irq_ctrl_test.sv
module fixed_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] OP_BASE = 4'd0, OP_MASK = 4'd1, OP_PULSE = 4'd2,
                         OP_ACK  = 4'd3, OP_EOI  = 4'd4, OP_RD    = 4'd5,
                         OP_IRQ  = 4'd6;

  function automatic logic [27:0] mk(input logic [3:0] op, input logic [7:0] arg,
                                     input logic [7:0] exp, input logic [7:0] rq);
    return {op, arg, exp, rq};
  endfunction

  localparam int NV = 44;
  localparam logic [27:0] VEC [NV] = '{
    mk(OP_BASE, 8'h40, 8'h00, 8'd4),
    mk(OP_RD,   8'h00, 8'h40, 8'd4),   // R4 base readback
    mk(OP_MASK, 8'hC6, 8'h00, 8'd1),
    mk(OP_RD,   8'h01, 8'h00, 8'd1),   // R1 unused bits ignored
    mk(OP_PULSE,8'h08, 8'h00, 8'd2),
    mk(OP_RD,   8'h03, 8'h20, 8'd2),   // R2 line 5 latched
    mk(OP_MASK, 8'h20, 8'h00, 8'd3),
    mk(OP_IRQ,  8'h00, 8'h00, 8'd3),   // R3 masked, no irq
    mk(OP_RD,   8'h03, 8'h20, 8'd3),   // R3 request kept
    mk(OP_MASK, 8'h00, 8'h00, 8'd3),
    mk(OP_IRQ,  8'h00, 8'h01, 8'd3),   // R3 unmasked raises irq
    mk(OP_PULSE,8'h04, 8'h00, 8'd2),
    mk(OP_ACK,  8'h00, 8'h44, 8'd4),   // R4 line 4 over line 5
    mk(OP_RD,   8'h02, 8'h10, 8'd6),   // R6
    mk(OP_RD,   8'h03, 8'h20, 8'd6),   // R6
    mk(OP_IRQ,  8'h00, 8'h00, 8'd5),   // R5 line 5 blocked
    mk(OP_ACK,  8'h00, 8'h47, 8'd9),   // R9
    mk(OP_RD,   8'h02, 8'h10, 8'd9),   // R9
    mk(OP_PULSE,8'h01, 8'h00, 8'd2),
    mk(OP_IRQ,  8'h00, 8'h01, 8'd5),   // R5 line 0 nests above 4
    mk(OP_ACK,  8'h00, 8'h40, 8'd4),   // R4
    mk(OP_RD,   8'h02, 8'h11, 8'd6),   // R6
    mk(OP_EOI,  8'h05, 8'h00, 8'd8),
    mk(OP_RD,   8'h02, 8'h11, 8'd8),   // R8 not in service
    mk(OP_RD,   8'h03, 8'h20, 8'd8),   // R8
    mk(OP_EOI,  8'h01, 8'h00, 8'd8),
    mk(OP_RD,   8'h02, 8'h11, 8'd8),   // R8 no such line
    mk(OP_EOI,  8'h00, 8'h00, 8'd7),
    mk(OP_RD,   8'h02, 8'h10, 8'd7),   // R7
    mk(OP_IRQ,  8'h00, 8'h00, 8'd5),   // R5 still blocked by 4
    mk(OP_EOI,  8'h04, 8'h00, 8'd7),
    mk(OP_IRQ,  8'h00, 8'h01, 8'd5),   // R5
    mk(OP_ACK,  8'h00, 8'h45, 8'd4),   // R4
    mk(OP_RD,   8'h03, 8'h00, 8'd6),   // R6
    mk(OP_RD,   8'h02, 8'h20, 8'd6),   // R6
    mk(OP_EOI,  8'h05, 8'h00, 8'd7),
    mk(OP_RD,   8'h02, 8'h00, 8'd7),   // R7
    mk(OP_PULSE,8'h03, 8'h00, 8'd2),
    mk(OP_ACK,  8'h00, 8'h40, 8'd4),   // R4 line 0 over line 3
    mk(OP_ACK,  8'h00, 8'h47, 8'd5),   // R5 line 3 blocked by 0
    mk(OP_EOI,  8'h00, 8'h00, 8'd7),
    mk(OP_ACK,  8'h00, 8'h43, 8'd4),   // R4
    mk(OP_EOI,  8'h03, 8'h00, 8'd7),
    mk(OP_IRQ,  8'h00, 8'h00, 8'd7)    // R7 all retired
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] src_i = '0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, vec_o;
  logic       inta_i = 1'b0;
  logic       cpu_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fixed_irq_ctrl uut (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .inta_i(inta_i),
    .vec_o(vec_o), .cpu_irq_o(cpu_irq_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp,
                       input int rq, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %02h expected %02h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input int rq);
    bus_addr = a;
    step();
    check(bus_rdata, exp, rq, "register read");
  endtask

  task automatic ack(input logic [7:0] exp, input int rq);
    inta_i = 1'b1;
    step();
    inta_i = 1'b0;
    check(vec_o, exp, rq, "vector");
  endtask

  task automatic irq(input logic exp, input int rq);
    step();
    check({7'd0, cpu_irq_o}, {7'd0, exp}, rq, "cpu irq");
  endtask

  task automatic pulse(input logic [3:0] m);
    src_i = src_i | m;
    step();
    src_i = src_i & ~m;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    src_i = 4'b0100;  // R2: high during reset, must not count as an edge
    @(negedge clk);
    step();
    rst = 1'b0;
    // R10 reset state
    check(vec_o, 8'h00, 10, "reset vector");
    check({7'd0, cpu_irq_o}, 8'h00, 10, "reset irq");
    check(bus_rdata, 8'h00, 10, "reset rdata");
    rd(2'd0, 8'h20, 10);
    rd(2'd1, 8'h39, 3);   // R3 all lines masked after reset
    rd(2'd2, 8'h00, 10);
    rd(2'd3, 8'h00, 2);   // R2 no edge from reset-high source
    src_i = '0;
    step();

    for (int k = 0; k < NV; k++) begin
      logic [3:0] op;
      logic [7:0] arg, exp;
      int rq;
      op  = VEC[k][27:24];
      arg = VEC[k][23:16];
      exp = VEC[k][15:8];
      rq  = int'(VEC[k][7:0]);
      case (op)
        OP_BASE:  wr(2'd0, arg);
        OP_MASK:  wr(2'd1, arg);
        OP_PULSE: pulse(arg[3:0]);
        OP_ACK:   ack(exp, rq);
        OP_EOI:   wr(2'd2, arg);
        OP_RD:    rd(arg[1:0], exp, rq);
        default:  irq(exp[0], rq);
      endcase
    end

    // R6: edge on a line in the same cycle as its acknowledge
    pulse(4'b0100);
    src_i[2] = 1'b1;
    ack(8'h44, 6);
    rd(2'd2, 8'h10, 6);
    rd(2'd3, 8'h10, 6);
    src_i[2] = 1'b0;
    wr(2'd2, 8'h04);
    ack(8'h44, 6);
    wr(2'd2, 8'h04);
    rd(2'd2, 8'h00, 7);

    // R2: a level held high latches only once
    src_i[1] = 1'b1;
    step();
    ack(8'h43, 2);
    wr(2'd2, 8'h03);
    rd(2'd3, 8'h00, 2);
    irq(1'b0, 2);
    src_i[1] = 1'b0;
    step();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule